// File: doc/BRIEF.md
# Transmit Streaming Error Monitor

This block sits beside the transmit half of a streaming serial link and turns low-level event inputs into a compact, registered error report. It observes the user streaming interface, which carries beats qualified by a valid strobe and delimited by start and end markers. It checks that the number of quiet cycles separating one burst from the next matches a programmed value. It also qualifies a rate-adaptation FIFO overflow level against the operating mode, and it forwards single-bit-corrected and double-bit-fatal ECC pulses.

Every error condition, and also a loss-of-lane-alignment event that has no error-vector position, sets a sticky status bit. Software clears a status bit by pulsing the matching clear input. A single interrupt line is raised whenever a set status bit has its enable set. The FIFO, the ECC decoders and link re-initialization live elsewhere and only appear here as inputs.

Top module: `tx_err_monitor`

## Requirements
- R1: `err_vec` is registered. It reflects inputs sampled at clock edge k in the cycle after edge k. Bit 0 is FIFO overflow, bit 1 is ECC corrected, bit 2 is ECC fatal, and bit 3 is burst spacing error.
- R2: A spacing error (`err_vec[3]`) pulses for exactly one cycle after a start beat (`s_valid & s_sob`) arrives outside a burst, when the idle count since the previous end beat differs from `cfg_idle_req`.
- R3: The first burst after reset is never checked for spacing.
- R4: An idle cycle is a cycle outside a burst with `s_valid` low. A valid beat outside a burst without a start marker is not counted. A burst runs from its start beat through its end beat, and a beat carrying both markers is a one-beat burst.
- R5: With `cfg_burst_mode` = 0, `err_vec[0]` follows `ev_ovf` one cycle later for as long as `ev_ovf` stays high.
- R6: With `cfg_burst_mode` = 1, `ev_ovf` is reported only in cycles from a start beat through the matching end beat. Outside those cycles it is ignored.
- R7: `ev_ecc_corr` and `ev_ecc_fatal` each produce a one-cycle pulse on `err_vec[1]` and `err_vec[2]` respectively, one cycle later.
- R8: `status[3:0]` sets in the same cycle as the matching `err_vec` bit rises, and `status[4]` marks lost lane alignment. Status bits hold until `clr_w1c` has a 1 in their position. A set in the same cycle as a clear wins.
- R9: `ev_align_lost` sets `status[4]` one cycle later and never drives any `err_vec` bit.
- R10: `irq` is high exactly when some bit is set in both `status` and `irq_en`.
- R11: Asserting `rst_n` low clears `err_vec`, `status`, `irq` and the spacing tracker immediately. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_req | input | CNT_W | Required idle cycles between bursts |
| cfg_burst_mode | input | 1 | 1 = burst mode, 0 = continuous mode |
| s_valid | input | 1 | Streaming beat valid |
| s_sob | input | 1 | Start-of-burst marker |
| s_eob | input | 1 | End-of-burst marker |
| ev_ovf | input | 1 | FIFO overflow condition (level) |
| ev_ecc_corr | input | 1 | ECC corrected pulse |
| ev_ecc_fatal | input | 1 | ECC fatal pulse |
| ev_align_lost | input | 1 | Loss of lane alignment pulse |
| clr_w1c | input | 5 | Status clear, one bit per status bit |
| irq_en | input | 5 | Interrupt enable per status bit |
| err_vec | output | 4 | Error pulses |
| status | output | 5 | Sticky status bits |
| irq | output | 1 | Interrupt |

## Verification
The bench targets idle gaps one short of, equal to and one beyond the programmed value. A design that counts the end beat, or the first quiet cycle, as idle would flag correct spacing and miss wrong spacing. Stray valid beats between bursts and one-beat bursts expose a counter that treats any valid low cycle, or any beat, as a burst boundary. Overflow raised just before a start beat and just after an end beat in burst mode separates a correct window from one that is shifted by a cycle. A clear issued in the same cycle as a new event catches a status register that lets the clear win and loses the event.

// File: rtl/txm_pkg.sv
package txm_pkg;
  localparam int ERR_W   = 4;
  localparam int ST_W    = 5;
  localparam int B_OVF   = 0;
  localparam int B_CORR  = 1;
  localparam int B_FATAL = 2;
  localparam int B_GAP   = 3;
  localparam int B_ALIGN = 4;
endpackage

// File: rtl/txm_gap_check.sv
module txm_gap_check #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_idle_req,
  input  logic             s_valid,
  input  logic             s_sob,
  input  logic             s_eob,
  output logic             gap_err,
  output logic             burst_act
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             in_burst_q, in_burst_d;
  logic             seen_end_q, seen_end_d;
  logic [CNT_W-1:0] idle_q, idle_d;
  logic             idle_en;
  logic             sob_beat, eob_beat;

  always_comb begin
    sob_beat   = s_valid & s_sob;
    eob_beat   = s_valid & s_eob;
    in_burst_d = in_burst_q;
    if (eob_beat)      in_burst_d = 1'b0;
    else if (sob_beat) in_burst_d = 1'b1;
    seen_end_d = seen_end_q | eob_beat;
    idle_en    = eob_beat | (~in_burst_q & ~s_valid & (idle_q != CNT_MAX));
    idle_d     = eob_beat ? '0 : idle_q + 1'b1;
    gap_err    = sob_beat & ~in_burst_q & seen_end_q & (idle_q != cfg_idle_req);
    burst_act  = in_burst_q | sob_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst_q <= 1'b0;
      seen_end_q <= 1'b0;
      idle_q     <= '0;
    end else begin
      in_burst_q <= in_burst_d;
      seen_end_q <= seen_end_d;
      if (idle_en) idle_q <= idle_d;
    end
  end
endmodule

// File: rtl/txm_ovf_qual.sv
module txm_ovf_qual (
  input  logic burst_mode,
  input  logic burst_act,
  input  logic ev_ovf,
  output logic ovf_flag
);
  always_comb begin
    ovf_flag = ev_ovf & (~burst_mode | burst_act);
  end
endmodule

// File: rtl/txm_status.sv
module txm_status #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] irq_en,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] stat_q, stat_d;
  logic         stat_en;

  always_comb begin
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    stat_en = |(set_vec | (clr_vec & stat_q));
    status  = stat_q;
    irq     = |(stat_q & irq_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/tx_err_monitor.sv
module tx_err_monitor
  import txm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_idle_req,
  input  logic             cfg_burst_mode,
  input  logic             s_valid,
  input  logic             s_sob,
  input  logic             s_eob,
  input  logic             ev_ovf,
  input  logic             ev_ecc_corr,
  input  logic             ev_ecc_fatal,
  input  logic             ev_align_lost,
  input  logic [ST_W-1:0]  clr_w1c,
  input  logic [ST_W-1:0]  irq_en,
  output logic [ERR_W-1:0] err_vec,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  logic             rst_meta_n, rst_q_n;
  logic             gap_err, burst_act, ovf_flag;
  logic [ERR_W-1:0] err_d, err_q;
  logic [ST_W-1:0]  stat_set;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  txm_gap_check #(.CNT_W(CNT_W)) u_gap (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .cfg_idle_req (cfg_idle_req),
    .s_valid      (s_valid),
    .s_sob        (s_sob),
    .s_eob        (s_eob),
    .gap_err      (gap_err),
    .burst_act    (burst_act)
  );

  txm_ovf_qual u_ovf (
    .burst_mode (cfg_burst_mode),
    .burst_act  (burst_act),
    .ev_ovf     (ev_ovf),
    .ovf_flag   (ovf_flag)
  );

  always_comb begin
    err_d          = '0;
    err_d[B_OVF]   = ovf_flag;
    err_d[B_CORR]  = ev_ecc_corr;
    err_d[B_FATAL] = ev_ecc_fatal;
    err_d[B_GAP]   = gap_err;
    stat_set              = '0;
    stat_set[ERR_W-1:0]   = err_d;
    stat_set[B_ALIGN]     = ev_align_lost;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) err_q <= '0;
    else          err_q <= err_d;
  end

  txm_status #(.W(ST_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .set_vec (stat_set),
    .clr_vec (clr_w1c),
    .irq_en  (irq_en),
    .status  (status),
    .irq     (irq)
  );

  assign err_vec = err_q;
endmodule

// File: rtl/tx_err_monitor_chk.sv
module tx_err_monitor_chk
  import txm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_burst_mode,
  input logic             s_valid,
  input logic             s_sob,
  input logic             ev_ovf,
  input logic             ev_ecc_corr,
  input logic             ev_ecc_fatal,
  input logic             ev_align_lost,
  input logic             burst_act,
  input logic [ST_W-1:0]  clr_w1c,
  input logic [ERR_W-1:0] err_vec,
  input logic [ST_W-1:0]  status
);
  AST_ECC_CORR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ecc_corr |=> err_vec[B_CORR]); // R7
  AST_ECC_FATAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_vec[B_FATAL] |-> $past(ev_ecc_fatal)); // R7
  AST_GAP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    err_vec[B_GAP] |-> $past(s_valid && s_sob)); // R2
  AST_OVF_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_burst_mode && ev_ovf) |=> err_vec[B_OVF]); // R5
  AST_OVF_OUTSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_burst_mode && ev_ovf && !burst_act) |=> !err_vec[B_OVF]); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_w1c)) == $past(status & ~clr_w1c))); // R8
  AST_ALIGN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_align_lost |=> status[B_ALIGN]); // R9
endmodule

bind tx_err_monitor tx_err_monitor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .cfg_burst_mode (cfg_burst_mode),
  .s_valid        (s_valid),
  .s_sob          (s_sob),
  .ev_ovf         (ev_ovf),
  .ev_ecc_corr    (ev_ecc_corr),
  .ev_ecc_fatal   (ev_ecc_fatal),
  .ev_align_lost  (ev_align_lost),
  .burst_act      (burst_act),
  .clr_w1c        (clr_w1c),
  .err_vec        (err_vec),
  .status         (status)
);

// File: tb/tx_err_monitor_bench.sv
`timescale 1ns/1ps
module tx_err_monitor_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cfg_idle_req;
  logic             cfg_burst_mode;
  logic             s_valid, s_sob, s_eob;
  logic             ev_ovf, ev_ecc_corr, ev_ecc_fatal, ev_align_lost;
  logic [4:0]       clr_w1c, irq_en;
  logic [3:0]       err_vec;
  logic [4:0]       status;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  bit       m_inb, m_seen;
  int       m_cnt;
  bit [4:0] m_stat;
  bit [3:0] m_err;

  always #4 clk = ~clk;

  tx_err_monitor #(.CNT_W(CNT_W)) u_tx_err_monitor (
    .clk(clk), .rst_n(rst_n), .cfg_idle_req(cfg_idle_req),
    .cfg_burst_mode(cfg_burst_mode), .s_valid(s_valid), .s_sob(s_sob),
    .s_eob(s_eob), .ev_ovf(ev_ovf), .ev_ecc_corr(ev_ecc_corr),
    .ev_ecc_fatal(ev_ecc_fatal), .ev_align_lost(ev_align_lost),
    .clr_w1c(clr_w1c), .irq_en(irq_en), .err_vec(err_vec),
    .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [3:0] exp_err(bit v, bit sob, bit eob, bit ovf, bit corr, bit fat);
    bit [3:0] e;
    bit sb;
    sb   = v & sob;
    e[3] = sb & !m_inb & m_seen & (m_cnt != int'(cfg_idle_req));
    e[0] = ovf & (!cfg_burst_mode | m_inb | sb);
    e[1] = corr;
    e[2] = fat;
    return e;
  endfunction

  task automatic model_reset();
    m_inb = 0; m_seen = 0; m_cnt = 0; m_stat = '0; m_err = '0;
  endtask

  task automatic tick(input bit v, input bit sob, input bit eob, input bit ovf,
                      input bit corr, input bit fat, input bit al, input bit [4:0] clr);
    s_valid = v; s_sob = sob; s_eob = eob; ev_ovf = ovf;
    ev_ecc_corr = corr; ev_ecc_fatal = fat; ev_align_lost = al; clr_w1c = clr;
    @(posedge clk); #1;
    m_err = exp_err(v, sob, eob, ovf, corr, fat);
    if (v & eob) m_cnt = 0;
    else if (!m_inb && !v && m_cnt < 255) m_cnt++;
    if (v & eob) m_inb = 0; else if (v & sob) m_inb = 1;
    m_seen = m_seen | (v & eob);
    m_stat = (m_stat & ~clr) | {al, m_err};
    check("R2 gap bit",      {7'd0, err_vec[3]}, {7'd0, m_err[3]});
    check("R5/R6 ovf bit",   {7'd0, err_vec[0]}, {7'd0, m_err[0]});
    check("R7 ecc bits",     {6'd0, err_vec[2:1]}, {6'd0, m_err[2:1]});
    check("R8 status",       {3'd0, status}, {3'd0, m_stat});
    check("R10 irq",         {7'd0, irq}, {7'd0, |(m_stat & irq_en)});
    s_valid = 0; s_sob = 0; s_eob = 0; ev_ovf = 0;
    ev_ecc_corr = 0; ev_ecc_fatal = 0; ev_align_lost = 0; clr_w1c = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0,0,0,0,0,0,0,5'd0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    #20;
    check("R11 err_vec in reset", {4'd0, err_vec}, 8'd0);
    check("R11 status in reset",  {3'd0, status}, 8'd0);
    check("R11 irq in reset",     {7'd0, irq}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    @(posedge clk); #1;
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    s_valid = 0; s_sob = 0; s_eob = 0; ev_ovf = 0; ev_ecc_corr = 0;
    ev_ecc_fatal = 0; ev_align_lost = 0; clr_w1c = '0;
    irq_en = 5'h1F; cfg_idle_req = 8'd3; cfg_burst_mode = 1'b0;
    apply_reset();

    // R3: first burst after reset not checked
    tick(1,1,0,0,0,0,0,0);
    check("R3 first burst unchecked", {7'd0, err_vec[3]}, 8'd0);
    tick(1,0,1,0,0,0,0,0);
    // R4: stray valid beat outside a burst does not count as idle
    tick(0,0,0,0,0,0,0,0); tick(1,0,0,0,0,0,0,0);
    tick(0,0,0,0,0,0,0,0); tick(0,0,0,0,0,0,0,0);
    tick(1,1,1,0,0,0,0,0);
    check("R4 stray beat not idle", {7'd0, err_vec[3]}, 8'd0);
    // R2: one short
    idle(2); tick(1,1,0,0,0,0,0,0);
    check("R2 short gap flagged", {7'd0, err_vec[3]}, 8'd1);
    tick(1,0,1,0,0,0,0,0);
    check("R2 single cycle pulse", {7'd0, err_vec[3]}, 8'd0);
    // R2: one long
    idle(4); tick(1,1,1,0,0,0,0,0);
    check("R2 long gap flagged", {7'd0, err_vec[3]}, 8'd1);
    tick(0,0,0,0,0,0,0,5'h1F);
    // R1: bit positions
    tick(0,0,0,0,1,0,0,0);
    check("R1 corrected at bit1", {4'd0, err_vec}, 8'h02);
    tick(0,0,0,0,0,1,0,0);
    check("R1 fatal at bit2", {4'd0, err_vec}, 8'h04);
    // R9: alignment loss only in status
    tick(0,0,0,0,0,0,1,5'h1F);
    check("R9 no err_vec bit", {4'd0, err_vec}, 8'h00);
    check("R9 status bit4", {7'd0, status[4]}, 8'd1);
    // R8: set wins over clear
    tick(0,0,0,0,0,0,1,5'h10);
    check("R8 set beats clear", {7'd0, status[4]}, 8'd1);
    tick(0,0,0,0,0,0,0,5'h10);
    check("R8 w1c clears", {7'd0, status[4]}, 8'd0);
    // R10: enable gating
    irq_en = 5'h00; tick(0,0,0,0,1,0,0,5'h1F);
    check("R10 masked irq low", {7'd0, irq}, 8'd0);
    irq_en = 5'h02; idle(1);
    check("R10 enabled irq high", {7'd0, irq}, 8'd1);
    irq_en = 5'h1F; tick(0,0,0,0,0,0,0,5'h1F);
    // R6: burst mode window
    cfg_burst_mode = 1'b1;
    tick(0,0,0,1,0,0,0,0);
    check("R6 ovf before start ignored", {7'd0, err_vec[0]}, 8'd0);
    tick(1,1,0,1,0,0,0,0);
    check("R6 ovf on start beat", {7'd0, err_vec[0]}, 8'd1);
    tick(1,0,1,1,0,0,0,0);
    check("R6 ovf on end beat", {7'd0, err_vec[0]}, 8'd1);
    tick(0,0,0,1,0,0,0,0);
    check("R6 ovf after end ignored", {7'd0, err_vec[0]}, 8'd0);
    // R5: continuous mode level
    cfg_burst_mode = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick(0,0,0,1,0,0,0,0);
      check("R5 ovf level follows", {7'd0, err_vec[0]}, 8'd1);
    end
    tick(0,0,0,0,0,0,0,5'h1F);
    check("R5 ovf drops", {7'd0, err_vec[0]}, 8'd0);

    // random traffic
    for (int b = 0; b < 1500; b++) begin
      int len, gap;
      if (b % 200 == 0) cfg_burst_mode = ~cfg_burst_mode;
      if (b % 50 == 0) irq_en = 5'($urandom);
      if (b % 300 == 0) cfg_idle_req = 8'($urandom_range(0, 5));
      len = $urandom_range(1, 4);
      gap = int'(cfg_idle_req) + $urandom_range(0, 2) - 1;
      if (gap < 0) gap = 0;
      for (int i = 0; i < gap; i++)
        tick(($urandom_range(0,9) == 0), 0, 0, ($urandom_range(0,5) == 0),
             ($urandom_range(0,19) == 0), ($urandom_range(0,19) == 0),
             ($urandom_range(0,39) == 0),
             ($urandom_range(0,7) == 0) ? 5'($urandom) : 5'd0);
      for (int i = 0; i < len; i++)
        tick(1, (i == 0), (i == len-1), ($urandom_range(0,5) == 0),
             ($urandom_range(0,19) == 0), ($urandom_range(0,19) == 0),
             ($urandom_range(0,39) == 0),
             ($urandom_range(0,7) == 0) ? 5'($urandom) : 5'd0);
    end

    // R11 + R3: mid-run reset clears and re-arms first-burst exemption
    tick(0,0,0,0,1,1,1,0);
    apply_reset();
    tick(1,1,1,0,0,0,0,0);
    check("R3 first burst after reset", {7'd0, err_vec[3]}, 8'd0);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule